// File: doc/BRIEF.md
# Interrupt Request Sampling Controller

This block sits beside a small processor core and collects every reason the core might have to break off its instruction stream. It brings in two external request pins: a non-maskable pin that responds to edges and may change at any moment relative to the clock, and a maskable pin that responds to levels. It also takes two internal exception strobes from the core, one for a divide fault and one for a single-step trap, together with the core's interrupt-enable flag and a strobe that marks the last cycle of each instruction.

Each time the core finishes an instruction, the controller chooses the most urgent outstanding request under a fixed order. It presents that request as a type number with a valid/acknowledge handshake. When the request came from the external maskable pin, the controller only flags it as external, because the type number for that case comes from outside this block. Requests of lower rank stay pending and are served at later instruction boundaries.

Top module: `irq_sampler`

## Requirements
- R1: After reset `req_valid` is 0. An `eoi` strobe with nothing pending leaves it at 0.
- R2: An NMI is accepted only when `nmi_pin` goes from low to high and is then seen high at two or more consecutive rising clock edges. A pulse seen at just one edge is discarded. An accepted NMI is issued with `req_ext`=0 and `req_type`=2.
- R3: The interrupt-enable flag `ie_flag` has no effect on NMI acceptance or issue.
- R4: An accepted NMI stays pending until it is acknowledged. If the pin remains high, no second NMI is accepted until the pin has gone low and then risen again.
- R5: INTR is level-sensitive. When the registered INTR level and `ie_flag` are both 1 at a boundary, the controller issues `req_ext`=1 with `req_type`=0. While `ie_flag` is 0, INTR produces no request. No INTR state is stored beyond the registered pin level.
- R6: INTR is registered on each rising edge. It is serviced at a boundary only when the pin was already high at the rising edge that opens the `eoi` cycle. A pin that first rises within the `eoi` cycle is missed at that boundary.
- R7: When several requests are outstanding, the controller serves them in a fixed order: divide fault (type 0) first, then single-step trap (type 1), then NMI (type 2), then INTR.
- R8: At most one request is issued per `eoi`. Requests that lose arbitration stay pending and are issued at later boundaries in priority order.
- R9: Once `req_valid` is 1, it stays 1, and `req_type` and `req_ext` stay unchanged, until `ack` is sampled high. Any `eoi` seen during that time is ignored.
- R10: `req_valid` rises only on the clock edge that samples `eoi` high. It does not rise on any other edge.
- R11: A one-cycle pulse on `div_err_req` or `step_trap_req` is held as pending until its request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin | input | 1 | Non-maskable request pin, asynchronous, edge-triggered |
| intr_pin | input | 1 | Maskable request pin, level-sensitive |
| ie_flag | input | 1 | Core interrupt-enable flag, masks INTR only |
| div_err_req | input | 1 | Divide-fault strobe from the core |
| step_trap_req | input | 1 | Single-step trap strobe from the core |
| eoi | input | 1 | High in the last cycle of each instruction |
| ack | input | 1 | Core accepts the presented request |
| req_valid | output | 1 | A request is being presented |
| req_type | output | TYPE_W | Type number (0, 1 or 2), or 0 for an external request |
| req_ext | output | 1 | Presented request comes from INTR |

## Verification
The main sweep tries every subset of the four request sources, once with the enable flag set and once with it clear. It then drains each subset one boundary at a time. This shows that the service order follows rank and not arrival, that nothing is lost or served twice, and that the flag masks only the level input. A sweep over NMI pulse widths from one to four cycles separates pulses that are long enough from glitches. A pin held high for a long time shows that one edge yields one request. Further patterns check INTR raised exactly in the boundary cycle against INTR raised a cycle earlier, and repeated boundary strobes while a request is still unacknowledged.

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int TYPE_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int NMI_MIN_HIGH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic              intr_pin,
  input  logic              ie_flag,
  input  logic              div_err_req,
  input  logic              step_trap_req,
  input  logic              eoi,
  input  logic              ack,
  output logic              req_valid,
  output logic [TYPE_W-1:0] req_type,
  output logic              req_ext
);
  localparam int CNT_W = $clog2(NMI_MIN_HIGH + 1);
  localparam logic [1:0] SRC_DIV  = 2'd0;
  localparam logic [1:0] SRC_STEP = 2'd1;
  localparam logic [1:0] SRC_NMI  = 2'd2;
  localparam logic [1:0] SRC_INTR = 2'd3;

  logic [SYNC_STAGES-1:0] nmi_sync;
  logic [CNT_W-1:0]       nmi_cnt;
  logic nmi_armed, nmi_pend, div_pend, step_pend, intr_q;
  logic [1:0] src_q, pick;
  logic nmi_s, intr_live, any_req, issue, fire, nmi_hit;

  assign nmi_s     = nmi_sync[SYNC_STAGES-1];
  assign nmi_hit   = nmi_s && nmi_armed && (nmi_cnt == CNT_W'(NMI_MIN_HIGH - 1));
  assign intr_live = intr_q & ie_flag;
  assign any_req   = div_pend | step_pend | nmi_pend | intr_live;
  assign pick      = div_pend ? SRC_DIV : step_pend ? SRC_STEP : nmi_pend ? SRC_NMI : SRC_INTR;
  assign issue     = eoi & ~req_valid & any_req;
  assign fire      = req_valid & ack;
  assign req_ext   = req_valid & (src_q == SRC_INTR);
  assign req_type  = (src_q == SRC_INTR) ? '0 : TYPE_W'(src_q);

  // Synchroniser for the asynchronous NMI pin; resets high so a pin held
  // high through reset is not taken as an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) nmi_sync <= '1;
    else        nmi_sync <= {nmi_sync[SYNC_STAGES-2:0], nmi_pin};
  end

  // Pulse-width qualifier and edge re-arm
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_cnt   <= '0;
      nmi_armed <= 1'b0;
    end else if (!nmi_s) begin
      nmi_cnt   <= '0;
      nmi_armed <= 1'b1;
    end else if (nmi_armed) begin
      if (nmi_hit) begin
        nmi_cnt   <= '0;
        nmi_armed <= 1'b0;
      end else begin
        nmi_cnt <= nmi_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_pend  <= 1'b0;
      div_pend  <= 1'b0;
      step_pend <= 1'b0;
      intr_q    <= 1'b0;
    end else begin
      intr_q    <= intr_pin;
      nmi_pend  <= (nmi_pend  & ~(fire && src_q == SRC_NMI))  | nmi_hit;
      div_pend  <= (div_pend  & ~(fire && src_q == SRC_DIV))  | div_err_req;
      step_pend <= (step_pend & ~(fire && src_q == SRC_STEP)) | step_trap_req;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      src_q     <= SRC_DIV;
    end else if (issue) begin
      req_valid <= 1'b1;
      src_q     <= pick;
    end else if (fire) begin
      req_valid <= 1'b0;
    end
  end

  // R9
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ack |=> req_valid && $stable(req_type) && $stable(req_ext));
  // R10
  issue_on_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(eoi));
  // R5
  intr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_ext |-> $past(ie_flag));
  // R7
  intr_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_ext |-> !$past(div_pend || step_pend || nmi_pend));
  // R2
  nmi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && !req_ext && req_type == TYPE_W'(2) |-> $past(nmi_pend) && !$past(div_pend || step_pend));
endmodule

// File: tb/tb_irq_sampler.sv
module tb_irq_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_pin = 0, intr_pin = 0, ie_flag = 0, div_err_req = 0, step_trap_req = 0, eoi = 0, ack = 0;
  logic req_valid, req_ext;
  logic [TW-1:0] req_type;
  int checks = 0, fails = 0, cycles = 0;

  irq_sampler #(.TYPE_W(TW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_eoi();
    eoi = 1; step(); eoi = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; step(); ack = 0;
  endtask

  task automatic nmi_pulse(input int w);
    nmi_pin = 1; step(w); nmi_pin = 0;
  endtask

  // Expects an internal request of type t at the next boundary, then acknowledges it
  task automatic expect_int(input int t, input string req);
    pulse_eoi();
    chk(req_valid === 1'b1, req, int'(req_valid), 1);
    chk(req_ext === 1'b0 && req_type === TW'(t), req, int'(req_type), t);
    pulse_ack();
    chk(req_valid === 1'b0, req, int'(req_valid), 0);
  endtask

  task automatic expect_none(input string req);
    pulse_eoi();
    chk(req_valid === 1'b0, req, int'(req_valid), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(4);
    // R1: reset state and empty boundary
    chk(req_valid === 1'b0, "R1", int'(req_valid), 0);
    expect_none("R1");

    // R7 R8 R11 R3 R5: every subset of sources, enable flag set and clear
    for (int m = 0; m < 32; m++) begin
      bit d, s, n, i, e;
      d = m[0]; s = m[1]; n = m[2]; i = m[3]; e = m[4];
      ie_flag = e; intr_pin = i;
      if (n) nmi_pulse(3);
      div_err_req = d; step_trap_req = s; step(); div_err_req = 0; step_trap_req = 0;
      step(6);
      if (d) expect_int(0, "R7 R11 divide first");
      if (s) expect_int(1, "R7 R11 step second");
      if (n) expect_int(2, "R7 R3 nmi third");
      if (i && e) begin
        pulse_eoi();
        chk(req_valid === 1'b1 && req_ext === 1'b1, "R5 intr issued", int'(req_ext), 1);
        chk(req_type === '0, "R5 intr type", int'(req_type), 0);
        pulse_ack();
      end
      if (i && !e) expect_none("R5 intr masked");
      intr_pin = 0; step(2);
      expect_none("R8 drained");
      ie_flag = 0;
    end

    // R2 R3: pulse width sweep with enable flag clear
    for (int w = 1; w <= 4; w++) begin
      nmi_pulse(w); step(6);
      if (w >= 2) expect_int(2, "R2 R3 width accepted");
      else        expect_none("R2 glitch rejected");
    end

    // R4: held-high pin gives one request until it returns low
    nmi_pin = 1; step(20);
    expect_int(2, "R4 first edge");
    step(5);
    expect_none("R4 no retrigger while high");
    nmi_pin = 0; step(4);
    nmi_pulse(3); step(6);
    expect_int(2, "R4 re-armed");

    // R6: INTR raised within the boundary cycle is missed, then caught
    ie_flag = 1; intr_pin = 1; eoi = 1; step(); eoi = 0;
    chk(req_valid === 1'b0, "R6 late intr missed", int'(req_valid), 0);
    pulse_eoi();
    chk(req_valid === 1'b1 && req_ext === 1'b1, "R6 intr caught", int'(req_ext), 1);
    pulse_ack();
    intr_pin = 0; ie_flag = 0; step(2);

    // R9 R10 R8: hold while unacknowledged, eoi ignored, no issue without eoi
    div_err_req = 1; step(); div_err_req = 0; step(3);
    chk(req_valid === 1'b0, "R10 no eoi no issue", int'(req_valid), 0);
    pulse_eoi();
    step_trap_req = 1; eoi = 1;
    for (int k = 0; k < 3; k++) begin
      step(); step_trap_req = 0;
      chk(req_valid === 1'b1 && req_type === TW'(0), "R9 held", int'(req_type), 0);
    end
    eoi = 0;
    pulse_ack();
    chk(req_valid === 1'b0, "R9 released", int'(req_valid), 0);
    expect_int(1, "R8 step issued later");
    expect_none("R1 idle at end");

    finish_run();
  end
endmodule